// File: doc/BRIEF.md
# Pixel to bus-cycle packer

This block sits between a pixel source and a parallel display bus. It takes pixels of 12, 16, 18 or 24 bits and turns each one into the sequence of bus words that the chosen bus width needs. The bus may be 8, 9, 12 or 16 bits wide. From the pixel size and the bus width it picks one of four cycle formats: one word per pixel, two words per pixel, three words per pixel, or three words for every pair of pixels. Slices always leave most significant first.

A frame begins with a one-cycle start pulse that comes with a total pixel count, normally width times height. The block then accepts exactly that many pixels on its ready/valid input and sends the packed words on a ready/valid output. Every word carries a flag marking it as pixel data. When the consumer takes the last word, the busy indication clears by itself and a one-cycle completion pulse is raised. The pixel size, the bus width and the count are captured at start and are held for the whole frame.

Top module: `pix_bus_packer`

## Requirements
- R1: Pixel size code `cfg_dtype` 0/1/2/3 means 12/16/18/24 bits. Bus width code `cfg_bus` 0/1/2/3 means 8/9/12/16 bits. If bits-per-pixel equals the bus width, or twice it, or three times it, a frame has 1, 2 or 3 words per pixel. If twice bits-per-pixel equals three bus widths, each pixel pair yields 3 words. Any other pairing is unsupported.
- R2: A start pulse is ignored, with busy, `pix_ready` and `bus_valid` staying low, when the pairing is unsupported or the count is zero.
- R3: In the whole-pixel formats, word k of a pixel (k = 0 first) carries pixel bits [bpp-1-k·W -: W], where W is the bus width. Each word is right-aligned in `bus_word`, its bits above W are zero, and `bus_is_data` is high. Pixel bits at and above bpp are ignored.
- R4: In the pair format, with h = W/2 and pixels A then B: word 0 is A[bpp-1:h]; word 1 is {A[h-1:0], B[bpp-1:W]}; word 2 is B[W-1:0].
- R5: In the pair format, when the count is odd, the final lone pixel A yields two words. The first is A[bpp-1:h]. The second is A[h-1:0] shifted up by h, with its low h bits zero.
- R6: Exactly the given count of pixels is accepted per frame. `pix_ready` is low whenever no frame is in progress.
- R7: `busy` is high in the cycle after an accepted start pulse. A start pulse while busy has no effect on the frame's length or contents.
- R8: `frame_done` is high for exactly one cycle: the cycle after the handshake of the frame's last word. `busy` is low in that same cycle. Neither `frame_done` nor `busy` falls any earlier.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_word` does not change.
- R10: After synchronous reset, `busy`, `bus_valid`, `pix_ready` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dtype | input | 2 | Pixel size code, captured at start |
| cfg_bus | input | 2 | Bus width code, captured at start |
| start | input | 1 | One-cycle frame start request |
| pix_total | input | CNT_W (16) | Pixels in the frame |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Input pixel accepted when high with valid |
| pix_data | input | PIX_W (24) | Pixel, right-aligned |
| bus_valid | output | 1 | Output word valid |
| bus_ready | input | 1 | Consumer takes the word |
| bus_word | output | BUS_W (16) | Bus word, right-aligned |
| bus_is_data | output | 1 | Marks the word as pixel data |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle completion pulse |

## Verification
`busy` rises one cycle after the start pulse. A pixel handshake makes its group's first word valid two clock edges later: one edge loads the group and the next registers the word. `frame_done` follows the last word's handshake by exactly one edge. The bench drives and samples only at falling edges, shortly after them. At each falling edge it records which handshakes the next rising edge will complete, so every word is compared against the arithmetic expectation in the order it is taken. Completion is then checked at the very next falling edge, and its clearing at the one after. Stalls and pixel gaps come from fixed patterns, and the frame lengths are chosen so that the pair format ends on both an even and an odd pixel.

// File: rtl/pix_pack_pkg.sv
`timescale 1ns/1ps
package pix_pack_pkg;
  typedef enum logic [1:0] {
    FMT_1_1 = 2'd0,
    FMT_2_1 = 2'd1,
    FMT_3_1 = 2'd2,
    FMT_3_2 = 2'd3
  } cyc_fmt_e;

  function automatic int bpp_of(input logic [1:0] code);
    case (code)
      2'd0:    return 12;
      2'd1:    return 16;
      2'd2:    return 18;
      default: return 24;
    endcase
  endfunction

  function automatic int bus_of(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 9;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/pix_fmt_sel.sv
`timescale 1ns/1ps
module pix_fmt_sel
  import pix_pack_pkg::*;
#(
  parameter int SZ_W = 5
) (
  input  logic [1:0]      dtype,
  input  logic [1:0]      bus,
  output cyc_fmt_e        fmt,
  output logic [1:0]      n_xfer,
  output logic            ok,
  output logic [SZ_W-1:0] bpp,
  output logic [SZ_W-1:0] wid
);
  always_comb begin
    int b;
    int w;
    b      = bpp_of(dtype);
    w      = bus_of(bus);
    bpp    = SZ_W'(b);
    wid    = SZ_W'(w);
    ok     = 1'b1;
    fmt    = FMT_1_1;
    n_xfer = 2'd1;
    if (b == w) begin
      fmt    = FMT_1_1;
      n_xfer = 2'd1;
    end else if (b == 2 * w) begin
      fmt    = FMT_2_1;
      n_xfer = 2'd2;
    end else if (b == 3 * w) begin
      fmt    = FMT_3_1;
      n_xfer = 2'd3;
    end else if (2 * b == 3 * w) begin
      fmt    = FMT_3_2;
      n_xfer = 2'd3;
    end else begin
      ok = 1'b0;
    end
  end
endmodule

// File: rtl/pix_word_slicer.sv
`timescale 1ns/1ps
module pix_word_slicer
  import pix_pack_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int SZ_W  = 5
) (
  input  cyc_fmt_e         fmt,
  input  logic [SZ_W-1:0]  bpp,
  input  logic [SZ_W-1:0]  wid,
  input  logic [1:0]       slot,
  input  logic [PIX_W-1:0] p0,
  input  logic [PIX_W-1:0] p1,
  output logic [BUS_W-1:0] word
);
  always_comb begin
    logic [PIX_W-1:0] mask_w;
    logic [PIX_W-1:0] mask_h;
    logic [PIX_W-1:0] acc;
    int half;
    int sh;
    half   = int'(wid) / 2;
    mask_w = PIX_W'((64'd1 << wid) - 64'd1);
    mask_h = PIX_W'((64'd1 << half) - 64'd1);
    sh     = int'(bpp) - (int'(slot) + 1) * int'(wid);
    acc    = '0;
    if (fmt == FMT_3_2) begin
      case (slot)
        2'd0:    acc = p0 >> half;
        2'd1:    acc = ((p0 & mask_h) << half) | (p1 >> wid);
        default: acc = p1 & mask_w;
      endcase
    end else if (sh >= 0) begin
      acc = (p0 >> sh) & mask_w;
    end
    word = acc[BUS_W-1:0];
  end
endmodule

// File: rtl/pix_bus_packer.sv
`timescale 1ns/1ps
module pix_bus_packer
  import pix_pack_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int BUS_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_dtype,
  input  logic [1:0]       cfg_bus,
  input  logic             start,
  input  logic [CNT_W-1:0] pix_total,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [BUS_W-1:0] bus_word,
  output logic             bus_is_data,
  output logic             busy,
  output logic             frame_done
);
  localparam int SZ_W = $clog2(PIX_W + 1);

  cyc_fmt_e        sel_fmt, fmt_q;
  logic [1:0]      sel_n, grp_n, slot;
  logic            sel_ok;
  logic [SZ_W-1:0] sel_bpp, sel_wid, bpp_q, wid_q;
  logic [CNT_W-1:0] left;
  logic            grp_full, held, bus_last;
  logic [PIX_W-1:0] p0, p1, pix_m;
  logic [BUS_W-1:0] slice_word;

  pix_fmt_sel #(.SZ_W(SZ_W)) fmt_i (
    .dtype(cfg_dtype), .bus(cfg_bus), .fmt(sel_fmt), .n_xfer(sel_n),
    .ok(sel_ok), .bpp(sel_bpp), .wid(sel_wid)
  );

  pix_word_slicer #(.PIX_W(PIX_W), .BUS_W(BUS_W), .SZ_W(SZ_W)) slc_i (
    .fmt(fmt_q), .bpp(bpp_q), .wid(wid_q), .slot(slot),
    .p0(p0), .p1(p1), .word(slice_word)
  );

  assign pix_ready = busy && !grp_full && (left != '0);
  assign pix_m     = pix_data & PIX_W'((64'd1 << bpp_q) - 64'd1);

  logic take_pix, emit, last_slot, word_gone;
  assign take_pix  = pix_valid && pix_ready;
  assign emit      = grp_full && (!bus_valid || bus_ready);
  assign last_slot = (slot == grp_n - 2'd1);
  assign word_gone = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; frame_done <= 1'b0; left <= '0;
      fmt_q <= FMT_1_1; bpp_q <= '0; wid_q <= '0; grp_n <= 2'd1;
      grp_full <= 1'b0; held <= 1'b0; slot <= 2'd0;
      p0 <= '0; p1 <= '0;
      bus_valid <= 1'b0; bus_word <= '0; bus_last <= 1'b0; bus_is_data <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!busy) begin
        if (start && sel_ok && (pix_total != '0)) begin
          busy     <= 1'b1;
          left     <= pix_total;
          fmt_q    <= sel_fmt;
          bpp_q    <= sel_bpp;
          wid_q    <= sel_wid;
          grp_full <= 1'b0;
          held     <= 1'b0;
          slot     <= 2'd0;
        end
      end else begin
        if (take_pix) begin
          left <= left - 1'b1;
          if (fmt_q == FMT_3_2) begin
            if (held) begin
              p1 <= pix_m; grp_full <= 1'b1; grp_n <= 2'd3; held <= 1'b0;
            end else if (left > 1) begin
              p0 <= pix_m; held <= 1'b1;
            end else begin
              p0 <= pix_m; p1 <= '0; grp_full <= 1'b1; grp_n <= 2'd2;
            end
          end else begin
            p0 <= pix_m;
            grp_full <= 1'b1;
            case (fmt_q)
              FMT_2_1: grp_n <= 2'd2;
              FMT_3_1: grp_n <= 2'd3;
              default: grp_n <= 2'd1;
            endcase
          end
        end
        if (emit) begin
          bus_word    <= slice_word;
          bus_valid   <= 1'b1;
          bus_is_data <= 1'b1;
          bus_last    <= last_slot && (left == '0);
          if (last_slot) begin
            slot     <= 2'd0;
            grp_full <= 1'b0;
          end else begin
            slot <= slot + 2'd1;
          end
        end else if (word_gone) begin
          bus_valid <= 1'b0;
        end
        if (word_gone && bus_last && !emit) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
          bus_last   <= 1'b0;
        end
      end
    end
  end

  // R9: a stalled word is held
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_word));
  // R8: completion is a single-cycle pulse with busy already low
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !busy && !bus_valid);
  // R7: busy only rises after a start request
  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R3: word bits above the bus width stay zero
  assert_word_range_R3: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> ((32'(bus_word) >> wid_q) == 32'd0));
  // R6: no output while idle
  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_valid);
endmodule

// File: tb/pix_bus_packer_tb.sv
`timescale 1ns/1ps
module pix_bus_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_dtype = '0, cfg_bus = '0;
  logic        start = 1'b0;
  logic [15:0] pix_total = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [15:0] bus_word;
  logic        bus_is_data, busy, frame_done;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  pix_bus_packer dut_i (
    .clk(clk), .rst(rst), .cfg_dtype(cfg_dtype), .cfg_bus(cfg_bus),
    .start(start), .pix_total(pix_total), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_word(bus_word), .bus_is_data(bus_is_data),
    .busy(busy), .frame_done(frame_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pixv(input int i, input int seed);
    return ((i * 32'h5A3C97) + (seed * 32'h1F3) + 32'hC3A5E1) & 32'hFFFFFF;
  endfunction

  // returns words per pixel (1..3), 4 for the pair format, 0 if unsupported
  function automatic int fmt_of(input int b, input int w);
    if ((b % w) == 0 && (b / w) <= 3) return b / w;
    if (((2 * b) % w) == 0 && (2 * b / w) == 3) return 4;
    return 0;
  endfunction

  task automatic run_frame(input int dt, input int bw, input int n, input bit mid, input int rp);
    int bl[4] = '{12, 16, 18, 24};
    int wl[4] = '{8, 9, 12, 16};
    int b, w, f, h, nexp, got, idx, cyc, prev_word;
    int exp_w[64];
    bit fin, stall;
    b = bl[dt]; w = wl[bw]; f = fmt_of(b, w); h = w / 2; nexp = 0;
    for (int i = 0; i < n; i++) begin
      int a = pixv(i, dt * 4 + bw) & ((1 << b) - 1);
      if (f != 4) begin
        for (int k = 0; k < f; k++) begin
          exp_w[nexp] = (a >> (b - (k + 1) * w)) & ((1 << w) - 1);
          nexp++;
        end
      end else if ((i % 2) == 0 && i + 1 < n) begin
        int c = pixv(i + 1, dt * 4 + bw) & ((1 << b) - 1);
        exp_w[nexp]   = a >> h;
        exp_w[nexp+1] = ((a & ((1 << h) - 1)) << h) | (c >> w);
        exp_w[nexp+2] = c & ((1 << w) - 1);
        nexp += 3;
      end else if ((i % 2) == 0) begin
        exp_w[nexp]   = a >> h;
        exp_w[nexp+1] = (a & ((1 << h) - 1)) << h;
        nexp += 2;
      end
    end
    @(negedge clk);
    cfg_dtype = 2'(dt); cfg_bus = 2'(bw); pix_total = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R7 busy after start", int'(busy), 1);
    got = 0; idx = 0; cyc = 0; fin = 0; stall = 0; prev_word = 0;
    while (!fin && cyc < 600) begin
      pix_valid = (cyc % 4) != 2;
      pix_data  = 24'(pixv(idx, dt * 4 + bw)) | (24'hFFFFFF << b);
      bus_ready = (rp == 0) ? 1'b1 : ((cyc + rp) % 3) != 0;
      if (mid && cyc == 3) begin start = 1'b1; pix_total = 16'(n + 4); end
      else start = 1'b0;
      #1;
      if (stall) begin
        chk("R9 held valid", int'(bus_valid), 1);
        chk("R9 held word", int'(bus_word), prev_word);
      end
      if (frame_done) chk("R8 early completion", 1, 0);
      if (pix_valid && pix_ready) idx++;
      if (bus_valid && bus_ready) begin
        string req;
        if (f != 4) req = "R3 slice";
        else if ((n % 2) == 1 && got >= nexp - 2) req = "R5 lone tail";
        else req = "R4 pair pack";
        if (got < nexp) chk(req, int'(bus_word), exp_w[got]);
        else chk("R1 extra word", 1, 0);
        chk("R3 data flag", int'(bus_is_data), 1);
        got++;
        if (got == nexp) fin = 1;
      end
      stall = bus_valid && !bus_ready;
      prev_word = int'(bus_word);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    #1;
    if (!fin) chk("R8 frame never ended", 0, 1);
    chk("R8 done pulse", int'(frame_done), 1);
    chk("R8 busy low at done", int'(busy), 0);
    chk("R1 word count", got, nexp);
    chk(mid ? "R7 start while busy ignored" : "R6 pixels taken", idx, n);
    chk("R6 not ready when idle", int'(pix_ready), 0);
    pix_valid = 1'b0; bus_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 done one cycle", int'(frame_done), 0);
    chk("R6 no output after done", int'(bus_valid), 0);
  endtask

  task automatic try_ignored(input int dt, input int bw, input int n);
    @(negedge clk);
    cfg_dtype = 2'(dt); cfg_bus = 2'(bw); pix_total = 16'(n); start = 1'b1;
    pix_valid = 1'b1; bus_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk("R2 busy stays low", int'(busy), 0);
    chk("R2 not ready", int'(pix_ready), 0);
    repeat (2) @(negedge clk);
    #1;
    chk("R2 no words", int'(bus_valid), 0);
    chk("R2 no completion", int'(frame_done), 0);
    pix_valid = 1'b0;
  endtask

  initial begin
    #750000;
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int bl[4] = '{12, 16, 18, 24};
    int wl[4] = '{8, 9, 12, 16};
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset busy", int'(busy), 0);
    chk("R10 reset valid", int'(bus_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 ready low", int'(pix_ready), 0);
    chk("R10 done low", int'(frame_done), 0);
    chk("R10 valid low", int'(bus_valid), 0);
    for (int dt = 0; dt < 4; dt++) begin
      for (int bw = 0; bw < 4; bw++) begin
        if (fmt_of(bl[dt], wl[bw]) == 0) begin
          try_ignored(dt, bw, 3);
        end else begin
          for (int n = 1; n <= 5; n++) run_frame(dt, bw, n, 1'b0, n % 3);
          try_ignored(dt, bw, 0);
        end
      end
    end
    run_frame(3, 0, 3, 1'b1, 1);
    run_frame(0, 0, 5, 1'b1, 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule